// File: doc/BRIEF.md
# Endpoint Buffer Region Allocator

This block manages a shared endpoint packet-buffer address space in fixed 512-byte allocation units. An occupancy bitmap records which units are in use. A chip places one instance on the transmit side and one on the receive side. Each instance has its own base address, its own usable-unit limit and its own bitmap.

An allocation request carries an endpoint's maximum packet size and a slot count.
- The block rounds the packet size up to a power of two. This is the segment.
- It multiplies the segment by the slot count plus one. This is the region size in bytes.
- It converts the region size to whole units.
- It searches the bitmap from unit 0 upward for the first run of free units that is long enough.
- If a run fits, it marks the run used and returns the run's byte address. If no run fits, it raises a failure flag.

A free request carries the region's address and the same packet size and slot count. It clears the same run of units.

Requests enter on a valid/ready handshake:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low.
- `req_ready` stays low from acceptance until one cycle after the matching `done` pulse. One request is therefore in flight at a time, and back-pressure lasts exactly as long as the search.
- `base_addr` and `limit` are sampled when an allocation is accepted.

Top module: `fifo_region_alloc`

## Requirements
- R1: The region needs ceil((slots+1) * seg / 512) units, where seg is the smallest power of two that is at least the max packet size. A max packet size of 0 counts as 1 byte.
- R2: An allocation takes the lowest-indexed run of free units that is long enough (first fit).
- R3: An allocated run is contiguous, lies wholly below `limit`, and sets exactly the needed number of bits.
- R4: On success `rsp_addr` equals the base address plus the starting unit index times 512, and `fail` is 0.
- R5: When no run fits, `fail` is 1 with `done`, and the bitmap is unchanged.
- R6: A free request clears the units from (req_addr - base_addr)/512 for the number of units given by R1, and no others.
- R7: Freeing units that are already clear has no effect on later allocations.
- R8: `done` is a one-cycle pulse. It follows a free one cycle after acceptance. It follows an allocation start+need cycles after acceptance on success, or max(limit,1) cycles after acceptance on failure. The search never takes more than 128 cycles.
- R9: `req_ready` is low from acceptance until the cycle after `done`, then high again. A request is taken only when valid and ready are both high.
- R10: After reset the bitmap is empty, `req_ready` is 1, and `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | 32 | Byte address of unit 0 |
| limit | input | 8 | Number of usable units (0 to 128) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_maxp | input | 11 | Endpoint max packet size in bytes |
| req_slots | input | 2 | Slot count; the region holds slots+1 segments |
| req_addr | input | 32 | Region byte address (free only) |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Allocation found no fitting run; valid with done |
| rsp_addr | output | 32 | Region byte address; valid with done on a successful allocation |

## Verification
The bitmap cannot be read directly. A wrong bit therefore shows up only in later requests:
- A stray set bit appears as an allocation that skips a free gap, or that fails early.
- A stray clear bit appears as two live regions handed out at overlapping addresses.
- Either fault also shifts the latency of the next search. The start+need timing rule exposes it in the same request that first touches the bad unit.

A faulty run counter or run-start register shows up as a wrong `rsp_addr` or a mistimed `done` on the very next allocation. To catch these faults, a behavioural model tracks every unit. It predicts each address and each completion cycle, and it is compared on every clock of each request.

// File: rtl/fba_pkg.sv
package fba_pkg;
  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } fba_op_e;
endpackage

// File: rtl/fba_size_calc.sv
// Converts max packet size and slot count into allocation units.
module fba_size_calc #(
  parameter int MAXP_W  = 11,
  parameter int SLOT_W  = 2,
  parameter int UNIT_LG = 9,
  parameter int CNT_W   = 8
) (
  input  logic [MAXP_W-1:0] maxp,
  input  logic [SLOT_W-1:0] slots,
  output logic [CNT_W-1:0]  units
);
  localparam int SEG_W = MAXP_W + 1;
  localparam int SZ_W  = MAXP_W + SLOT_W + 2;

  logic [SEG_W-1:0] seg;
  logic [SZ_W-1:0]  size_b;
  logic [SZ_W-1:0]  round_b;

  // smallest power of two not below maxp (maxp of 0 yields 1)
  always_comb begin
    seg = SEG_W'(1);
    for (int k = 0; k < MAXP_W; k++) begin
      if (seg < {1'b0, maxp}) seg = seg << 1;
    end
  end

  assign size_b  = (SZ_W'(slots) + SZ_W'(1)) * SZ_W'(seg);
  assign round_b = (size_b + SZ_W'((1 << UNIT_LG) - 1)) >> UNIT_LG;
  assign units   = CNT_W'(round_b);
endmodule

// File: rtl/fba_bitmap.sv
// Occupancy bitmap with run set and run clear.
module fba_bitmap #(
  parameter int MAP_BITS = 128,
  parameter int LO_W     = 23,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [LO_W-1:0]     lo,
  input  logic [CNT_W-1:0]    cnt,
  output logic [MAP_BITS-1:0] used
);
  logic [LO_W:0]         hi;
  logic [MAP_BITS-1:0]   in_run;

  assign hi = {1'b0, lo} + (LO_W+1)'(cnt);

  for (genvar i = 0; i < MAP_BITS; i++) begin : g_run
    localparam logic [LO_W:0] IV = (LO_W+1)'(i);
    assign in_run[i] = (IV >= {1'b0, lo}) && (IV < hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      used <= '0;
    else if (set_en) used <= used | in_run;
    else if (clr_en) used <= used & ~in_run;
  end

  // R6: a free never turns a bit on
  p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((used & ~$past(used)) == '0));
  // R3: an allocation never turns a bit off
  p_set_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((~used & $past(used)) == '0));
endmodule

// File: rtl/fifo_region_alloc.sv
module fifo_region_alloc #(
  parameter int ADDR_W   = 32,
  parameter int MAXP_W   = 11,
  parameter int SLOT_W   = 2,
  parameter int UNIT_LG  = 9,
  parameter int MAP_BITS = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              base_addr,
  input  logic [$clog2(MAP_BITS+1)-1:0]  limit,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_op,
  input  logic [MAXP_W-1:0]              req_maxp,
  input  logic [SLOT_W-1:0]              req_slots,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic                           done,
  output logic                           fail,
  output logic [ADDR_W-1:0]              rsp_addr
);
  import fba_pkg::*;

  localparam int IDX_W = $clog2(MAP_BITS + 1);
  localparam int IB    = $clog2(MAP_BITS);
  localparam int CNT_W = IDX_W;
  localparam int OFF_W = ADDR_W - UNIT_LG;

  logic                busy;
  logic [IDX_W-1:0]    idx, run_start, lim_q;
  logic [CNT_W-1:0]    run_len, need_q, units;
  logic [ADDR_W-1:0]   base_q;
  logic [MAP_BITS-1:0] used;
  logic                acc, bit_free, hit, last;
  logic [IDX_W:0]      idx_inc;
  logic [OFF_W-1:0]    lo_free, lo_mux;
  logic [CNT_W-1:0]    cnt_mux;

  fba_size_calc #(
    .MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_LG(UNIT_LG), .CNT_W(CNT_W)
  ) u_size (
    .maxp(req_maxp), .slots(req_slots), .units(units)
  );

  assign req_ready = !busy && !done;
  assign acc       = req_valid && req_ready;

  assign bit_free = !used[idx[IB-1:0]];
  assign idx_inc  = {1'b0, idx} + 1'b1;
  assign hit      = (lim_q != '0) && bit_free && ((run_len + 1'b1) == need_q);
  assign last     = (lim_q == '0) || (idx_inc >= {1'b0, lim_q});

  assign lo_free = OFF_W'((req_addr - base_addr) >> UNIT_LG);
  assign lo_mux  = busy ? OFF_W'(run_start) : lo_free;
  assign cnt_mux = busy ? need_q : units;

  fba_bitmap #(
    .MAP_BITS(MAP_BITS), .LO_W(OFF_W), .CNT_W(CNT_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(busy && hit),
    .clr_en(acc && (req_op == OP_FREE)),
    .lo(lo_mux), .cnt(cnt_mux), .used(used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      rsp_addr  <= '0;
      idx       <= '0;
      run_len   <= '0;
      run_start <= '0;
      need_q    <= '0;
      base_q    <= '0;
      lim_q     <= '0;
    end else begin
      done <= 1'b0;
      if (acc) begin
        if (req_op == OP_ALLOC) begin
          busy      <= 1'b1;
          idx       <= '0;
          run_len   <= '0;
          run_start <= '0;
          need_q    <= units;
          base_q    <= base_addr;
          lim_q     <= limit;
        end else begin
          done <= 1'b1;
          fail <= 1'b0;
        end
      end else if (busy) begin
        if (hit) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          fail     <= 1'b0;
          rsp_addr <= base_q + (ADDR_W'(run_start) << UNIT_LG);
        end else if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          fail <= 1'b1;
        end else begin
          idx     <= idx_inc[IDX_W-1:0];
          run_len <= bit_free ? run_len + 1'b1 : '0;
          if (!bit_free) run_start <= idx_inc[IDX_W-1:0];
        end
      end
    end
  end

  // search-length watch counter for the R8 bound
  logic [IDX_W:0] scan_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scan_cyc <= '0;
    else if (busy) scan_cyc <= scan_cyc + 1'b1;
    else           scan_cyc <= '0;
  end

  p_scan_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (scan_cyc < (IDX_W+1)'(MAP_BITS)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fail_keeps_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (used == $past(used)));
  p_alloc_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && $past(busy)) |->
      ($countones(used) == $past($countones(used)) + int'(need_q)));
  p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && $past(busy)) |->
      ((rsp_addr[UNIT_LG-1:0] == base_q[UNIT_LG-1:0]) && (rsp_addr >= base_q)));
endmodule

// File: tb/sim_fifo_region_alloc.sv
`timescale 1ns/1ps
module sim_fifo_region_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = 32'h1000;
  logic [7:0]  limit = 8'd128;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [10:0] req_maxp = '0;
  logic [1:0]  req_slots = '0;
  logic [31:0] req_addr = '0;
  logic        done, fail;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit mdl [128];
  int last_addr;

  always #5 clk = ~clk;

  fifo_region_alloc u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .limit(limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_maxp(req_maxp), .req_slots(req_slots), .req_addr(req_addr),
    .done(done), .fail(fail), .rsp_addr(rsp_addr)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int units_of(int maxp, int slots);
    int seg = 1;
    while (seg < maxp) seg = seg * 2;
    return ((slots + 1) * seg + 511) / 512;
  endfunction

  function automatic int first_fit(int need, int lim);
    int run = 0;
    for (int i = 0; i < lim; i++) begin
      if (!mdl[i]) begin
        run++;
        if (run == need) return i - need + 1;
      end else run = 0;
    end
    return -1;
  endfunction

  // one request, compared against the model on every clock until it completes
  task automatic do_req(bit op, int maxp, int slots, int addr, string tag);
    int need = units_of(maxp, slots);
    int start = 0, lat = 0;
    bit exp_fail = 1'b0;
    if (op == 1'b0) begin
      start    = first_fit(need, int'(limit));
      exp_fail = (start < 0);
      lat      = exp_fail ? ((limit == 0) ? 1 : int'(limit)) : start + need;
    end
    @(negedge clk);
    req_op = op; req_maxp = 11'(maxp); req_slots = 2'(slots);
    req_addr = addr; req_valid = 1'b1;
    chk(req_ready == 1'b1, {tag, " R9 ready before"}, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= lat; c++) begin
      if (c > 0) @(negedge clk);
      if (c < lat) begin
        if (done !== 1'b0 || req_ready !== 1'b0) begin
          chk(1'b0, {tag, " R8 early done/R9 ready"}, {done, req_ready}, 0);
          return;
        end
      end
    end
    chk(done == 1'b1, {tag, " R8 done timing"}, done, 1);
    chk(fail == exp_fail, {tag, " R5 fail flag"}, fail, exp_fail);
    if (op == 1'b0 && !exp_fail) begin
      chk(rsp_addr == 32'(base_addr + start * 512), {tag, " R4 address"},
          rsp_addr, base_addr + start * 512);
      for (int i = start; i < start + need; i++) mdl[i] = 1'b1;
      last_addr = base_addr + start * 512;
    end
    if (op == 1'b1) begin
      int lo = (addr - int'(base_addr)) / 512;
      for (int i = lo; i < lo + need; i++) if (i >= 0 && i < 128) mdl[i] = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, {tag, " R8/R9 pulse end"},
        {done, req_ready}, 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1 && done == 1'b0 && fail == 1'b0, "R10 reset",
        {req_ready, done, fail}, 3'b100);

    do_req(1'b0, 1024, 2, 0, "R1 six units");        // start 0
    do_req(1'b0, 512, 1, 0, "R1 two units");         // start 6
    do_req(1'b0, 100, 0, 0, "R1 small packet");      // start 8
    do_req(1'b0, 0, 0, 0, "R1 zero packet");         // start 9
    do_req(1'b1, 1024, 2, 32'h1000, "R6 free first"); // clears 0..5
    do_req(1'b0, 513, 1, 0, "R2 first fit reuse");   // 4 units at 0
    do_req(1'b0, 512, 2, 0, "R3 gap too small");     // 3 units, skips 4..5
    do_req(1'b1, 1024, 1, 32'h1000 + 100 * 512, "R7 free clear bits");
    do_req(1'b0, 64, 1, 0, "R7 alloc after no-op free");
    limit = 8'd14;
    do_req(1'b0, 1024, 2, 0, "R5 fail under limit");
    do_req(1'b0, 512, 1, 0, "R5 map kept after fail");
    limit = 8'd0;
    do_req(1'b0, 64, 0, 0, "R8 zero limit fail");
    limit = 8'd128;
    base_addr = 32'h0002_0000;
    for (int k = 0; k < 17; k++) do_req(1'b0, 1024, 3, 0, "R3 fill map");
    do_req(1'b1, 1024, 3, int'(last_addr), "R6 free last");
    do_req(1'b0, 2000, 1, 0, "R1 round to 2048");
    summary();
    $finish;
  end
endmodule